// File: doc/BRIEF.md
# Tile Gateway with Local Bypass

The tile gateway connects two processor cores on one tile to two destinations: the tile's own message buffer (a 16 KB local store) and the port of the mesh router. Each core presents one request at a time, with a 32-bit core-physical address. The top byte of that address selects an entry in a software-writable translation table. The entry gives a destination tile, a router port and the high bits of a wider system address. If the entry's bypass flag is set, the request is served straight from the local buffer. Otherwise, the gateway sends a single mesh packet and waits for the router to return the acknowledge.

The two cores share one service path, which is granted in round-robin order. A request that loses arbitration waits in a per-core holding slot. While a bypassed request is alive, including every cycle it spends waiting for the grant, a per-core suppression output stays high and the gateway keeps that request off the mesh. A bypassed request can therefore never leak onto the mesh as a duplicate packet. A request whose entry has bypass clear goes out on the mesh even when it targets the local tile. Such a request therefore pays the full router round trip.

Top module: `tile_gateway`

## Requirements
- R1: For a request whose entry has bypass clear, the mesh packet carries the entry's tile and port fields, and the system address {entry high bits (10), core address bits 23:0}. `meshSrc` is the requesting core number and `meshWe` is the request's write flag.
- R2: A table write on the configuration port changes how later requests are handled. The table is read when a core's request is accepted, so every request accepted after the write cycle uses the new entry.
- R3: When both cores are waiting at a grant decision, the grant goes to the core that was not granted most recently. After reset, core 1 counts as the most recent, so core 0 wins the first contended decision.
- R4: A request whose entry has bypass set raises `lbReq` for exactly one cycle, with `lbAddr` equal to core address bits 13:0. Addresses above 16 KB therefore wrap into the local buffer. The request emits no mesh packet.
- R5: `meshSuppress[i]` is high in every cycle from the acceptance of a bypassed request from core i until its acknowledge, including the cycles in which that request is stalled behind the other core.
- R6: A request whose entry has bypass clear emits exactly one mesh packet, even if it targets the local tile. `meshValid` and the packet fields are held until `meshReady` is seen. The request completes only on `meshAckValid`.
- R7: Each core has at most one request outstanding. `coreReady[i]` is low from acceptance until the acknowledge. The acknowledge is a one-cycle `coreAck[i]` pulse with `coreRdata[i]` taken from `lbRdata` or `meshAckRdata`. At most one core is acknowledged per cycle.
- R8: After reset, `coreReady` is 2'b11, and `coreAck`, `lbReq`, `meshValid` and `meshSuppress` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreValid | input | 2 | Per-core request valid |
| coreReady | output | 2 | Per-core holding slot free |
| coreWe | input | 2 | Per-core write flag |
| coreAddr | input | 2x32 | Per-core core-physical address |
| coreWdata | input | 2x32 | Per-core write data |
| coreAck | output | 2 | Per-core completion pulse |
| coreRdata | output | 2x32 | Per-core read data, valid with coreAck |
| cfgWe | input | 1 | Table entry write strobe |
| cfgIdx | input | 8 | Table entry index |
| cfgBypass | input | 1 | Bypass flag for the written entry |
| cfgTile | input | 6 | Destination tile for the written entry |
| cfgPort | input | 3 | Router port for the written entry |
| cfgSysHi | input | 10 | High system address bits for the written entry |
| lbReq | output | 1 | Local buffer access strobe |
| lbWe | output | 1 | Local buffer write flag |
| lbAddr | output | 14 | Local buffer byte address |
| lbWdata | output | 32 | Local buffer write data |
| lbAck | input | 1 | Local buffer completion |
| lbRdata | input | 32 | Local buffer read data |
| meshValid | output | 1 | Mesh packet valid |
| meshReady | input | 1 | Router accepts packet |
| meshSrc | output | 1 | Originating core |
| meshWe | output | 1 | Packet is a write |
| meshTile | output | 6 | Destination tile |
| meshPort | output | 3 | Destination router port |
| meshSysAddr | output | 34 | System address |
| meshWdata | output | 32 | Packet write data |
| meshAckValid | input | 1 | Returned acknowledge from router |
| meshAckRdata | input | 32 | Returned read data |
| meshSuppress | output | 2 | Per-core mesh suppression for live bypassed requests |

## Verification
The assertions assume that `lbAck` arrives only while a local access is outstanding, that `meshAckValid` arrives only after a packet has been accepted, and that neither source returns more than one acknowledge per access. The bench models the buffer and the router as single-outstanding responders that reply once and only after a request has been seen, and those responders follow these rules. It also assumes that every table entry a request can select has been written before use. The bench writes every index it addresses before the first request that uses it. The router model lowers `meshReady` on a fixed pattern so that held packets occur. Under contention, the bench pairs a bypassed request with a mesh request so that the bypassed one must wait.

// File: rtl/tgw_pkg.sv
`timescale 1ns/1ps
package tgw_pkg;
  // the arbiter is a two-way round robin
  parameter int NCORE    = 2;
  parameter int ADDR_W   = 32;
  parameter int DATA_W   = 32;
  parameter int IDX_W    = 8;
  parameter int TILE_W   = 6;
  parameter int PORT_W   = 3;
  parameter int SYSHI_W  = 10;
  parameter int LB_AW    = 14;
  localparam int OFS_W   = ADDR_W - IDX_W;
  localparam int SYS_AW  = SYSHI_W + OFS_W;
  localparam int LUT_N   = 1 << IDX_W;

  typedef struct packed {
    logic               bypass;
    logic [TILE_W-1:0]  tile;
    logic [PORT_W-1:0]  port;
    logic [SYSHI_W-1:0] sysHi;
  } lutEntry_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic sel;
    logic lbIssue;
    logic meshIssue;
    logic lbDone;
    logic meshDone;
  } strobe_t;
endpackage

// File: rtl/tgw_ctrl.sv
`timescale 1ns/1ps
module tgw_ctrl
  import tgw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCORE-1:0] hValid,
  input  logic [NCORE-1:0] hBypass,
  input  logic             lbAck,
  input  logic             meshReady,
  input  logic             meshAckValid,
  output strobe_t          st
);
  typedef enum logic [2:0] {S_IDLE, S_LB_REQ, S_LB_WAIT, S_MS_REQ, S_MS_WAIT} state_t;

  state_t state;
  logic   owner;
  logic   lastGrant;
  logic   pick;

  always_comb begin
    if (hValid[0] && hValid[1]) pick = ~lastGrant;
    else                        pick = ~hValid[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      owner     <= 1'b0;
      lastGrant <= 1'b1;
    end else begin
      case (state)
        S_IDLE: if (|hValid) begin
          owner     <= pick;
          lastGrant <= pick;
          state     <= hBypass[pick] ? S_LB_REQ : S_MS_REQ;
        end
        S_LB_REQ:  state <= S_LB_WAIT;
        S_LB_WAIT: if (lbAck) state <= S_IDLE;
        S_MS_REQ:  if (meshReady) state <= S_MS_WAIT;
        S_MS_WAIT: if (meshAckValid) state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    st.sel       = owner;
    st.lbIssue   = (state == S_LB_REQ);
    st.meshIssue = (state == S_MS_REQ);
    st.lbDone    = (state == S_LB_WAIT) && lbAck;
    st.meshDone  = (state == S_MS_WAIT) && meshAckValid;
  end

  // R4: a bypassed request never reaches the mesh issue phase
  p_mesh_not_bypass_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.meshIssue |-> !hBypass[owner]);

  // R3: a contended decision goes against the previous winner
  p_rr_alternate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && (&hValid)) |=> (owner != $past(lastGrant)));

  // R6: a packet not taken by the router is held unchanged
  p_mesh_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.meshIssue && !meshReady) |=> (st.meshIssue && $stable(owner)));

  // R7: the served core keeps its request held until completion
  p_owner_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> hValid[owner]);
endmodule

// File: rtl/tgw_dp.sv
`timescale 1ns/1ps
module tgw_dp
  import tgw_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NCORE-1:0]              coreValid,
  output logic [NCORE-1:0]              coreReady,
  input  logic [NCORE-1:0]              coreWe,
  input  logic [NCORE-1:0][ADDR_W-1:0]  coreAddr,
  input  logic [NCORE-1:0][DATA_W-1:0]  coreWdata,
  output logic [NCORE-1:0]              coreAck,
  output logic [NCORE-1:0][DATA_W-1:0]  coreRdata,
  input  logic                          cfgWe,
  input  logic [IDX_W-1:0]              cfgIdx,
  input  lutEntry_t                     cfgEntry,
  input  strobe_t                       st,
  output logic [NCORE-1:0]              hValid,
  output logic [NCORE-1:0]              hBypass,
  output logic                          lbReq,
  output logic                          lbWe,
  output logic [LB_AW-1:0]              lbAddr,
  output logic [DATA_W-1:0]             lbWdata,
  input  logic [DATA_W-1:0]             lbRdata,
  output logic                          meshValid,
  output logic                          meshSrc,
  output logic                          meshWe,
  output logic [TILE_W-1:0]             meshTile,
  output logic [PORT_W-1:0]             meshPort,
  output logic [SYS_AW-1:0]             meshSysAddr,
  output logic [DATA_W-1:0]             meshWdata,
  input  logic [DATA_W-1:0]             meshAckRdata,
  output logic [NCORE-1:0]              meshSuppress
);
  lutEntry_t lut [LUT_N];

  always_ff @(posedge clk) begin
    if (cfgWe) lut[cfgIdx] <= cfgEntry;
  end

  logic [ADDR_W-1:0] hAddr [NCORE];
  logic [DATA_W-1:0] hData [NCORE];
  logic              hWe   [NCORE];
  lutEntry_t         hEnt  [NCORE];
  logic              done;

  assign done = st.lbDone | st.meshDone;

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    logic accept;
    logic mine;
    assign accept = coreValid[i] & ~hValid[i];
    assign mine   = (st.sel == 1'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        hValid[i]  <= 1'b0;
        coreAck[i] <= 1'b0;
      end else begin
        coreAck[i] <= done && mine;
        if (done && mine)  hValid[i] <= 1'b0;
        else if (accept)   hValid[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (accept) begin
        hAddr[i] <= coreAddr[i];
        hData[i] <= coreWdata[i];
        hWe[i]   <= coreWe[i];
        hEnt[i]  <= lut[coreAddr[i][ADDR_W-1 -: IDX_W]];
      end
      if (done && mine) coreRdata[i] <= st.lbDone ? lbRdata : meshAckRdata;
    end

    assign coreReady[i]    = ~hValid[i];
    assign hBypass[i]      = hEnt[i].bypass;
    assign meshSuppress[i] = hValid[i] & hEnt[i].bypass;

    // R5: suppression survives every stalled cycle of a bypassed request
    p_suppress_held_r5: assert property (@(posedge clk) disable iff (!rstN)
      (hValid[i] && hEnt[i].bypass && !(done && mine)) |=> meshSuppress[i]);

    // R7: an acknowledged core is free for its next request
    p_ack_frees_r7: assert property (@(posedge clk) disable iff (!rstN)
      coreAck[i] |-> coreReady[i]);
  end

  // local buffer path, low address bits only
  assign lbReq   = st.lbIssue;
  assign lbWe    = hWe[st.sel];
  assign lbAddr  = hAddr[st.sel][LB_AW-1:0];
  assign lbWdata = hData[st.sel];

  // mesh path, gated by the live suppression of the served core
  assign meshValid   = st.meshIssue & ~meshSuppress[st.sel];
  assign meshSrc     = st.sel;
  assign meshWe      = hWe[st.sel];
  assign meshTile    = hEnt[st.sel].tile;
  assign meshPort    = hEnt[st.sel].port;
  assign meshSysAddr = {hEnt[st.sel].sysHi, hAddr[st.sel][OFS_W-1:0]};
  assign meshWdata   = hData[st.sel];

  // R7: one acknowledge at a time
  p_ack_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(coreAck));

  // R4: local and mesh paths are never active together
  p_paths_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(lbReq && meshValid));
endmodule

// File: rtl/tile_gateway.sv
`timescale 1ns/1ps
module tile_gateway
  import tgw_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NCORE-1:0]              coreValid,
  output logic [NCORE-1:0]              coreReady,
  input  logic [NCORE-1:0]              coreWe,
  input  logic [NCORE-1:0][ADDR_W-1:0]  coreAddr,
  input  logic [NCORE-1:0][DATA_W-1:0]  coreWdata,
  output logic [NCORE-1:0]              coreAck,
  output logic [NCORE-1:0][DATA_W-1:0]  coreRdata,
  input  logic                          cfgWe,
  input  logic [IDX_W-1:0]              cfgIdx,
  input  logic                          cfgBypass,
  input  logic [TILE_W-1:0]             cfgTile,
  input  logic [PORT_W-1:0]             cfgPort,
  input  logic [SYSHI_W-1:0]            cfgSysHi,
  output logic                          lbReq,
  output logic                          lbWe,
  output logic [LB_AW-1:0]              lbAddr,
  output logic [DATA_W-1:0]             lbWdata,
  input  logic                          lbAck,
  input  logic [DATA_W-1:0]             lbRdata,
  output logic                          meshValid,
  input  logic                          meshReady,
  output logic                          meshSrc,
  output logic                          meshWe,
  output logic [TILE_W-1:0]             meshTile,
  output logic [PORT_W-1:0]             meshPort,
  output logic [SYS_AW-1:0]             meshSysAddr,
  output logic [DATA_W-1:0]             meshWdata,
  input  logic                          meshAckValid,
  input  logic [DATA_W-1:0]             meshAckRdata,
  output logic [NCORE-1:0]              meshSuppress
);
  strobe_t          st;
  logic [NCORE-1:0] hValid;
  logic [NCORE-1:0] hBypass;
  lutEntry_t        cfgEntry;

  assign cfgEntry = '{bypass: cfgBypass, tile: cfgTile, port: cfgPort, sysHi: cfgSysHi};

  tgw_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .hValid(hValid), .hBypass(hBypass),
    .lbAck(lbAck), .meshReady(meshReady), .meshAckValid(meshAckValid), .st(st)
  );

  tgw_dp i_dp (
    .clk(clk), .rstN(rstN),
    .coreValid(coreValid), .coreReady(coreReady), .coreWe(coreWe),
    .coreAddr(coreAddr), .coreWdata(coreWdata), .coreAck(coreAck), .coreRdata(coreRdata),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgEntry(cfgEntry),
    .st(st), .hValid(hValid), .hBypass(hBypass),
    .lbReq(lbReq), .lbWe(lbWe), .lbAddr(lbAddr), .lbWdata(lbWdata), .lbRdata(lbRdata),
    .meshValid(meshValid), .meshSrc(meshSrc), .meshWe(meshWe), .meshTile(meshTile),
    .meshPort(meshPort), .meshSysAddr(meshSysAddr), .meshWdata(meshWdata),
    .meshAckRdata(meshAckRdata), .meshSuppress(meshSuppress)
  );
endmodule

// File: tb/test_tile_gateway.sv
`timescale 1ns/1ps
module test_tile_gateway;
  import tgw_pkg::*;

  localparam int HOP = 4;
  localparam logic [5:0] HOME_TILE = 6'd9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]        coreValid = '0, coreReady, coreWe = '0, coreAck;
  logic [1:0][31:0]  coreAddr = '0, coreWdata = '0, coreRdata;
  logic              cfgWe = 0, cfgBypass = 0;
  logic [7:0]        cfgIdx = '0;
  logic [5:0]        cfgTile = '0;
  logic [2:0]        cfgPort = '0;
  logic [9:0]        cfgSysHi = '0;
  logic              lbReq, lbWe, lbAck = 0;
  logic [13:0]       lbAddr;
  logic [31:0]       lbWdata, lbRdata = '0;
  logic              meshValid, meshReady = 0, meshSrc, meshWe, meshAckValid = 0;
  logic [5:0]        meshTile;
  logic [2:0]        meshPort;
  logic [33:0]       meshSysAddr;
  logic [31:0]       meshWdata, meshAckRdata = '0;
  logic [1:0]        meshSuppress;

  tile_gateway i_tile_gateway (.*);

  int nChk = 0, nBad = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  // router loopback model: HOP cycles out, HOP cycles back
  int cyc = 0, pktCount = 0, meshCnt = 0;
  logic        srcLog [64];
  logic [5:0]  lastTile;
  logic [2:0]  lastPort;
  logic [33:0] lastSys;
  logic        lastWe;
  always @(negedge clk) begin
    cyc++;
    meshAckValid = 0;
    if (meshCnt > 0) begin
      meshCnt--;
      if (meshCnt == 0) begin
        meshAckValid = 1;
        meshAckRdata = lastSys[31:0] ^ 32'h5A5A_0000;
      end
    end
    meshReady = (cyc % 3) != 0;
    if (meshValid && meshReady) begin
      srcLog[pktCount % 64] = meshSrc;
      pktCount++;
      lastTile = meshTile; lastPort = meshPort; lastSys = meshSysAddr; lastWe = meshWe;
      meshCnt = 2 * HOP;
    end
  end

  // local buffer model
  logic [31:0] lbMem [64];
  int lbCnt = 0, lbCount = 0;
  logic [13:0] lbLast;
  always @(negedge clk) begin
    lbAck = 0;
    if (lbCnt > 0) begin
      lbCnt--;
      if (lbCnt == 0) begin lbAck = 1; lbRdata = lbMem[lbLast[7:2]]; end
    end
    if (lbReq) begin
      lbLast = lbAddr; lbCount++;
      if (lbWe) lbMem[lbAddr[7:2]] = lbWdata;
      lbCnt = 2;
    end
  end

  task automatic cfg(logic [7:0] idx, logic byp, logic [5:0] tile, logic [2:0] port, logic [9:0] hi);
    @(negedge clk);
    cfgWe = 1; cfgIdx = idx; cfgBypass = byp; cfgTile = tile; cfgPort = port; cfgSysHi = hi;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic req(int c, logic [31:0] addr, logic we, logic [31:0] wd,
                     output logic [31:0] rd, output logic rdyAfter, output int lat);
    @(negedge clk);
    coreValid[c] = 1; coreAddr[c] = addr; coreWe[c] = we; coreWdata[c] = wd;
    while (!coreReady[c]) @(negedge clk);
    @(negedge clk);
    coreValid[c] = 0;
    rdyAfter = coreReady[c];
    lat = 1;
    while (!coreAck[c]) begin @(negedge clk); lat++; end
    rd = coreRdata[c];
  endtask

  logic [31:0] rd, rd1;
  logic rdy, rdy1;
  int lat, lat1, p0, l0;

  task automatic t_reset();
    chk("R8 coreReady", coreReady, 2'b11);
    chk("R8 coreAck", coreAck, 0);
    chk("R8 lbReq", lbReq, 0);
    chk("R8 meshValid", meshValid, 0);
    chk("R8 meshSuppress", meshSuppress, 0);
  endtask

  task automatic t_translate();
    cfg(8'h12, 0, 6'd5, 3'd2, 10'h3C5);
    p0 = pktCount;
    req(0, 32'h12AB_CDE0, 0, 0, rd, rdy, lat);
    chk("R6 one packet", pktCount - p0, 1);
    chk("R1 tile", lastTile, 6'd5);
    chk("R1 port", lastPort, 3'd2);
    chk("R1 sysaddr", lastSys, {10'h3C5, 24'hAB_CDE0});
    chk("R1 src", srcLog[p0 % 64], 0);
    chk("R1 we", lastWe, 0);
    chk("R7 read data", rd, {10'h3C5, 24'hAB_CDE0} & 34'hFFFF_FFFF ^ 32'h5A5A_0000);
    chk("R7 ready low while outstanding", rdy, 0);
  endtask

  task automatic t_sameTile();
    cfg(8'h21, 0, HOME_TILE, 3'd0, 10'h001);
    p0 = pktCount; l0 = lbCount;
    req(1, 32'h2100_0040, 1, 32'h1234_5678, rd, rdy, lat);
    chk("R6 same-tile packet", pktCount - p0, 1);
    chk("R6 same-tile no local access", lbCount - l0, 0);
    chk("R6 round trip not shortened", lat >= 2 * HOP + 1, 1);
    chk("R1 write flag", lastWe, 1);
  endtask

  task automatic t_bypass();
    cfg(8'h40, 1, HOME_TILE, 3'd0, 10'h000);
    p0 = pktCount; l0 = lbCount;
    req(1, 32'h4000_7F04, 1, 32'hCAFE_F00D, rd, rdy, lat);
    chk("R4 no packet", pktCount - p0, 0);
    chk("R4 one local access", lbCount - l0, 1);
    chk("R4 wrapped address", lbLast, 14'h3F04);
    req(1, 32'h4000_3F04, 0, 0, rd, rdy, lat);
    chk("R4 wrap readback", rd, 32'hCAFE_F00D);
    chk("R4 no packet on read", pktCount - p0, 0);
  endtask

  task automatic t_rewrite();
    cfg(8'h40, 0, 6'd3, 3'd1, 10'h2AA);
    p0 = pktCount; l0 = lbCount;
    req(0, 32'h4000_0010, 0, 0, rd, rdy, lat);
    chk("R2 now mesh", pktCount - p0, 1);
    chk("R2 no local access", lbCount - l0, 0);
    chk("R2 new tile", lastTile, 6'd3);
  endtask

  task automatic t_roundRobin();
    req(1, 32'h1200_0100, 0, 0, rd, rdy, lat);
    p0 = pktCount;
    fork
      req(0, 32'h1200_0200, 0, 0, rd, rdy, lat);
      req(1, 32'h1200_0300, 0, 0, rd1, rdy1, lat1);
    join
    chk("R3 first after core1", srcLog[p0 % 64], 0);
    chk("R3 second", srcLog[(p0 + 1) % 64], 1);
    req(0, 32'h1200_0400, 0, 0, rd, rdy, lat);
    p0 = pktCount;
    fork
      req(0, 32'h1200_0500, 0, 0, rd, rdy, lat);
      req(1, 32'h1200_0600, 0, 0, rd1, rdy1, lat1);
    join
    chk("R3 first after core0", srcLog[p0 % 64], 1);
  endtask

  task automatic t_stalledBypass();
    bit held;
    int stall;
    cfg(8'h40, 1, HOME_TILE, 3'd0, 10'h000);
    p0 = pktCount; l0 = lbCount;
    held = 1; stall = 0;
    fork
      req(0, 32'h4000_0080, 1, 32'h0BAD_BEEF, rd, rdy, lat);
      req(1, 32'h1200_0700, 0, 0, rd1, rdy1, lat1);
      begin
        @(negedge clk); @(negedge clk);
        while (!coreAck[0]) begin
          if (!meshSuppress[0]) held = 0;
          stall++;
          @(negedge clk);
        end
      end
    join
    chk("R5 suppression held through stall", held, 1);
    chk("R5 bypass was stalled", stall > 2 * HOP, 1);
    chk("R4 only the mesh request left", pktCount - p0, 1);
    chk("R4 packet from core1", srcLog[p0 % 64], 1);
    chk("R4 local access", lbCount - l0, 1);
    chk("R4 local address", lbLast, 14'h0080);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_translate();
    t_sameTile();
    t_bypass();
    t_rewrite();
    t_roundRobin();
    t_stalledBypass();
    repeat (3) @(negedge clk);
    endRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    endRun();
  end
endmodule